// File: doc/BRIEF.md
# Two-Key Register Write Lock

This block guards a window of configuration registers against stray writes. The window starts out locked. It opens only after two 32-bit key words arrive, in order, at two kick registers that sit at consecutive word addresses. The first key goes to the lower kick address and the second key to the upper one. A zero written to either kick register closes the window again.

The block sits on a simple single-cycle register bus with a word address, write data, a write strobe and a combinational read-back. It drives a lock status flag. It also drives a qualified write enable that the protected registers use in place of the raw strobe. A write that hits the window while it is locked is dropped and sets a sticky violation flag. One scratch register at the base of the window stands in for the protected contents.

Top module: `two_key_lock`

## Requirements
- R1: After reset, `locked_o` is 1, the violation flag (status address 0x04, bit 0) reads 0, and the scratch register (address 0x10) reads 0.
- R2: Writing KEY0 = 0x68EF3490 to kick-low (0x02) and then KEY1 = 0xD172BC5A to kick-high (0x03) clears `locked_o` from the clock edge of the KEY1 write. Writes to non-kick addresses between the two keys do not cancel the pending first key.
- R3: KEY1 unlocks only when the most recent kick-low write was KEY0 and no kick-high write has followed it. Any other value written to kick-low, or any write to kick-high, cancels a pending first key.
- R4: A write of 0x00000000 to either kick register sets `locked_o` from the next edge.
- R5: A nonzero write to a kick register that neither completes the key sequence nor is zero leaves `locked_o` unchanged.
- R6: While unlocked, a write to 0x10..0x13 raises `prot_we_o` in the same cycle. A write to 0x10 updates the scratch register, which reads back at 0x10.
- R7: While locked, `prot_we_o` stays 0 and a write to 0x10 leaves the scratch register unchanged. Addresses outside 0x10..0x13 never raise `prot_we_o`.
- R8: A write to 0x10..0x13 while locked sets the violation flag. The flag stays set until a status write with bit 0 = 1. A status write with bit 0 = 0 leaves it set.
- R9: A read of either kick address returns `locked_o` in bit 0 and zeros in bits 31:1, never the written key.
- R10: A read of an unmapped address, or of 0x11..0x13, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Word address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Combinational read data for addr_i |
| locked_o | output | 1 | Window lock status |
| prot_we_o | output | 1 | Qualified write enable for the protected window |

## Verification
The bench builds the block with its default parameters: an 8-bit address, 32-bit data, kicks at 0x02/0x03, status at 0x04 and a four-word window at 0x10. With these values the window's edges (0x0F, 0x13, 0x14) and both kick addresses can be reached in directed sequences. The keys are the exact 32-bit words, so near-miss values and zero relocks land on the real comparators. A behavioural model tracks the lock, the pending first key, the flag and the scratch register, and the bench compares it with the outputs every cycle through unlock, cancel and relock orderings.

// File: rtl/two_key_lock_pkg.sv
package two_key_lock_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_KICK0,
    SEL_KICK1,
    SEL_STAT,
    SEL_PROT
  } sel_e;
endpackage

// File: rtl/tkl_decode.sv
module tkl_decode import two_key_lock_pkg::*; #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned KICK_ADDR  = 2,
  parameter int unsigned STAT_ADDR  = 4,
  parameter int unsigned PROT_BASE  = 16,
  parameter int unsigned PROT_WORDS = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              sel_o,
  output logic              scratch_hit_o
);
  localparam int unsigned ProtEnd = PROT_BASE + PROT_WORDS;

  int unsigned a;
  always_comb begin
    a = int'(addr_i);
    if (a == KICK_ADDR)                    sel_o = SEL_KICK0;
    else if (a == KICK_ADDR + 1)           sel_o = SEL_KICK1;
    else if (a == STAT_ADDR)               sel_o = SEL_STAT;
    else if (a >= PROT_BASE && a < ProtEnd) sel_o = SEL_PROT;
    else                                   sel_o = SEL_NONE;
    scratch_hit_o = (a == PROT_BASE);
  end
endmodule

// File: rtl/tkl_key_fsm.sv
module tkl_key_fsm #(
  parameter int unsigned          DATA_W = 32,
  parameter logic [DATA_W-1:0]    KEY0   = 32'h68EF3490,
  parameter logic [DATA_W-1:0]    KEY1   = 32'hD172BC5A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr0_i,
  input  logic              wr1_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              locked_o
);
  logic armed_q, locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b1;
      armed_q  <= 1'b0;
    end else begin
      if (wr0_i) begin
        armed_q <= (wdata_i == KEY0);
        if (wdata_i == '0) locked_q <= 1'b1;
      end
      if (wr1_i) begin
        armed_q <= 1'b0;
        if (armed_q && wdata_i == KEY1) locked_q <= 1'b0;
        else if (wdata_i == '0)         locked_q <= 1'b1;
      end
    end
  end

  assign locked_o = locked_q;

  // R2 / R3: opening needs an armed KEY1 write on kick-high
  a_r3_unlock_needs_keys: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked_q && $past(locked_q)) |-> $past(wr1_i && armed_q && wdata_i == KEY1));
  // R4: zero on a kick register relocks
  a_r4_zero_relocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr0_i || wr1_i) && wdata_i == '0) |=> locked_q);
  // R5: only a kick write changes the lock
  a_r5_lock_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr0_i && !wr1_i) |=> $stable(locked_q));
endmodule

// File: rtl/tkl_viol.sv
module tkl_viol (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic viol_o
);
  logic viol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    viol_q <= 1'b0;
    else if (set_i) viol_q <= 1'b1;
    else if (clr_i) viol_q <= 1'b0;
  end

  assign viol_o = viol_q;

  a_r8_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> viol_q);
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_q && !clr_i) |=> viol_q);
endmodule

// File: rtl/two_key_lock.sv
module two_key_lock import two_key_lock_pkg::*; #(
  parameter int unsigned       ADDR_W     = 8,
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       KICK_ADDR  = 2,
  parameter int unsigned       STAT_ADDR  = 4,
  parameter int unsigned       PROT_BASE  = 16,
  parameter int unsigned       PROT_WORDS = 4,
  parameter logic [DATA_W-1:0] KEY0       = 32'h68EF3490,
  parameter logic [DATA_W-1:0] KEY1       = 32'hD172BC5A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              locked_o,
  output logic              prot_we_o
);
  sel_e              sel;
  logic              scratch_hit, locked, viol;
  logic [DATA_W-1:0] scratch_q;

  tkl_decode #(
    .ADDR_W(ADDR_W), .KICK_ADDR(KICK_ADDR), .STAT_ADDR(STAT_ADDR),
    .PROT_BASE(PROT_BASE), .PROT_WORDS(PROT_WORDS)
  ) i_decode (
    .addr_i(addr_i), .sel_o(sel), .scratch_hit_o(scratch_hit)
  );

  tkl_key_fsm #(.DATA_W(DATA_W), .KEY0(KEY0), .KEY1(KEY1)) i_key_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr0_i(we_i && sel == SEL_KICK0),
    .wr1_i(we_i && sel == SEL_KICK1),
    .wdata_i(wdata_i), .locked_o(locked)
  );

  tkl_viol i_viol (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(we_i && sel == SEL_PROT && locked),
    .clr_i(we_i && sel == SEL_STAT && wdata_i[0]),
    .viol_o(viol)
  );

  assign prot_we_o = we_i && sel == SEL_PROT && !locked;
  assign locked_o  = locked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      scratch_q <= '0;
    else if (prot_we_o && scratch_hit) scratch_q <= wdata_i;
  end

  always_comb begin
    unique case (sel)
      SEL_KICK0, SEL_KICK1: rdata_o = DATA_W'(locked);
      SEL_STAT:             rdata_o = DATA_W'(viol);
      SEL_PROT:             rdata_o = scratch_hit ? scratch_q : '0;
      default:              rdata_o = '0;
    endcase
  end

  // R7: locked window never qualifies a write
  a_r7_locked_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> !prot_we_o);
  a_r7_scratch_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prot_we_o |=> $stable(scratch_q));
  // R9: kick reads carry only the lock bit
  a_r9_kick_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_KICK0 || sel == SEL_KICK1) |-> rdata_o == DATA_W'(locked_o));
endmodule

// File: tb/test_two_key_lock.sv
module test_two_key_lock;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] K0 = 32'h68EF3490;
  localparam logic [31:0] K1 = 32'hD172BC5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        locked, prot_we;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  bit          m_locked = 1, m_armed = 0, m_viol = 0;
  logic [31:0] m_scratch = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  two_key_lock i_two_key_lock (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .locked_o(locked), .prot_we_o(prot_we)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [7:0] a);
    if (a == 8'h02 || a == 8'h03) return {31'b0, m_locked};
    if (a == 8'h04) return {31'b0, m_viol};
    if (a == 8'h10) return m_scratch;
    return '0;
  endfunction

  // one bus cycle; compares the model with the ports every clock
  task automatic cyc(string tag, bit w, logic [7:0] a, logic [31:0] d);
    bit inprot, pw;
    bit n_locked, n_armed, n_viol;
    logic [31:0] n_scratch;
    @(negedge clk);
    we = w; addr = a; wdata = d;
    #(CLK_PERIOD/4);
    inprot = (a >= 8'h10 && a <= 8'h13);
    pw = w && inprot && !m_locked;
    chk({tag, " locked"}, {31'b0, locked}, {31'b0, m_locked});
    chk({tag, " prot_we"}, {31'b0, prot_we}, {31'b0, pw});
    chk({tag, " rdata"}, rdata, m_read(a));
    n_locked = m_locked; n_armed = m_armed; n_viol = m_viol; n_scratch = m_scratch;
    if (w) begin
      if (a == 8'h02) begin
        n_armed = (d == K0);
        if (d == 0) n_locked = 1;
      end else if (a == 8'h03) begin
        n_armed = 0;
        if (m_armed && d == K1) n_locked = 0;
        else if (d == 0) n_locked = 1;
      end else if (a == 8'h04) begin
        if (d[0]) n_viol = 0;
      end else if (inprot) begin
        if (m_locked) n_viol = 1;
        else if (a == 8'h10) n_scratch = d;
      end
    end
    @(posedge clk);
    m_locked = n_locked; m_armed = n_armed; m_viol = n_viol; m_scratch = n_scratch;
  endtask

  task automatic rd_expect(string tag, logic [7:0] a, logic [31:0] exp);
    cyc(tag, 0, a, 32'hFFFF_FFFF);
    @(negedge clk); we = 0; addr = a;
    #(CLK_PERIOD/4);
    chk({tag, " literal"}, rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    rst_n = 1'b1;
    // R1 reset state
    rd_expect("R1 kick0", 8'h02, 32'h1);
    rd_expect("R1 status", 8'h04, 32'h0);
    rd_expect("R1 scratch", 8'h10, 32'h0);
    // R7 / R8 locked write dropped, flag set
    cyc("R7 locked wr", 1, 8'h10, 32'hAAAA_5555);
    rd_expect("R7 scratch kept", 8'h10, 32'h0);
    rd_expect("R8 flag set", 8'h04, 32'h1);
    cyc("R8 clr0", 1, 8'h04, 32'h0);
    rd_expect("R8 flag kept", 8'h04, 32'h1);
    cyc("R8 clr1", 1, 8'h04, 32'h1);
    rd_expect("R8 flag clr", 8'h04, 32'h0);
    // R7 outside window, no flag
    cyc("R7 edge 0x14", 1, 8'h14, 32'h1);
    cyc("R7 edge 0x0F", 1, 8'h0F, 32'h1);
    rd_expect("R7 no flag", 8'h04, 32'h0);
    cyc("R8 top word", 1, 8'h13, 32'h7);
    rd_expect("R8 flag 0x13", 8'h04, 32'h1);
    cyc("R8 clr", 1, 8'h04, 32'h3);
    // R3 bad orderings
    cyc("R3 key1 alone", 1, 8'h03, K1);
    rd_expect("R3 still locked a", 8'h03, 32'h1);
    cyc("R3 k0", 1, 8'h02, K0);
    cyc("R3 junk k0", 1, 8'h02, 32'h55);
    cyc("R3 k1", 1, 8'h03, K1);
    rd_expect("R3 still locked b", 8'h02, 32'h1);
    cyc("R3 k0", 1, 8'h02, K0);
    cyc("R3 junk k1", 1, 8'h03, 32'h1234);
    cyc("R3 k1", 1, 8'h03, K1);
    rd_expect("R3 still locked c", 8'h02, 32'h1);
    cyc("R3 k0 near", 1, 8'h02, K0 ^ 32'h1);
    cyc("R3 k1", 1, 8'h03, K1);
    rd_expect("R3 still locked d", 8'h02, 32'h1);
    // R2 unlock with unrelated write in between
    cyc("R2 k0", 1, 8'h02, K0);
    cyc("R2 other", 1, 8'h20, 32'h9);
    cyc("R2 k1", 1, 8'h03, K1);
    rd_expect("R9 kick1 open", 8'h03, 32'h0);
    // R6 writes pass
    cyc("R6 wr scratch", 1, 8'h10, 32'hCAFE_F00D);
    cyc("R6 wr 0x13", 1, 8'h13, 32'h1);
    rd_expect("R6 scratch rd", 8'h10, 32'hCAFE_F00D);
    rd_expect("R10 0x11", 8'h11, 32'h0);
    rd_expect("R10 unmapped", 8'h7F, 32'h0);
    // R5 nonzero kick write keeps state
    cyc("R5 k0 nz", 1, 8'h02, 32'h1);
    cyc("R5 k1 nz", 1, 8'h03, K0);
    rd_expect("R5 still open", 8'h02, 32'h0);
    // R4 relock via kick-high, reopen, relock via kick-low
    cyc("R4 zero k1", 1, 8'h03, 32'h0);
    rd_expect("R4 locked a", 8'h02, 32'h1);
    cyc("R4 k0", 1, 8'h02, K0);
    cyc("R4 k1", 1, 8'h03, K1);
    rd_expect("R4 open", 8'h02, 32'h0);
    cyc("R4 zero k0", 1, 8'h02, 32'h0);
    rd_expect("R4 locked b", 8'h03, 32'h1);
    cyc("R7 blocked again", 1, 8'h10, 32'h1111_2222);
    rd_expect("R7 scratch kept", 8'h10, 32'hCAFE_F00D);
    @(negedge clk); we = 0;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule